// File: doc/BRIEF.md
# Time-Multiplexed Convolution MAC Engine

This block is the arithmetic core of a streaming convolution stage for 8-bit quantized networks. It takes one whole convolution window per input beat, holding one element per tap for each of several input feature maps, and produces one partial sum per output feature map. Every output feature map has its own lane, and each lane is a single multiply-accumulate unit. That unit is reused across all taps of the filter: it walks the window one tap per core clock, and inside the tap the products of the parallel input feature maps are first summed into one term.

Because each lane needs one core cycle per tap, the input side only advances on an internal enable. That enable fires once every `taps` cycles, where `taps` is the runtime filter size (K*K for a KxK filter). Layers with different filter sizes therefore run on the same hardware by changing `cfg_taps` between windows. Inputs and weights arrive already corrected for their zero points. Bias, activation and requantization belong to the next stage. Weights for all lanes sit in a small register file that is written over its own valid/ready stream before data flows.

Top module: `conv_mac_engine`

## Requirements
- R1: After reset `out_valid` is 0, and both `in_ready` and `wt_ready` are 1.
- R2: A weight beat is taken when `wt_valid` and `wt_ready` are both high. It writes `wt_data[f*8 +: 8]` as the signed weight of input map f at tap `wt_tap` of lane `wt_lane`. `wt_ready` is 0 from the cycle after a window is accepted until that window's last tap has been processed.
- R3: A window is taken when `in_valid` and `in_ready` are both high. `in_data[(t*NFM+f)*8 +: 8]` is the signed element of input map f at tap t. When taps > 1, `in_ready` is 0 in the cycle after an accept.
- R4: Lane l reports, as a signed 21-bit value at `out_data[l*21 +: 21]`, the sum over taps t < taps and input maps f of input(t,f) times weight(l,t,f).
- R5: Each window's sum starts from zero. Nothing from an earlier window leaks into it.
- R6: `cfg_taps` sets taps from 1 to 9. A value of 0, or any value above 9, selects 9. Window elements at tap positions at or above taps have no effect on the result.
- R7: With `out_ready` high, a window accepted at clock edge n gives `out_valid` high after edge n+taps. `out_valid` stays high for one cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. The lanes do not advance, and at most one further window is taken in and held.
- R9: All-extreme operands (-128 times -128, and -128 times 127, over every tap and map) give exact results with no wrap.
- R10: With data always offered and `out_ready` high, windows are accepted exactly taps cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (MAC) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_taps | input | 4 | Taps per window (K*K); 0 or above 9 selects 9 |
| wt_valid | input | 1 | Weight beat valid |
| wt_ready | output | 1 | Weight file writable (no window in progress) |
| wt_lane | input | 1 | Lane (output feature map) addressed by the beat |
| wt_tap | input | 4 | Tap addressed by the beat |
| wt_data | input | 16 | One signed 8-bit weight per input feature map |
| in_valid | input | 1 | Window beat valid |
| in_ready | output | 1 | Input enable: window can be taken this cycle |
| in_data | input | 144 | Window: 9 taps x 2 input maps x 8 bits |
| out_valid | output | 1 | Partial sums valid |
| out_ready | input | 1 | Downstream accepts partial sums |
| out_data | output | 42 | One signed 21-bit partial sum per lane |

## Verification
The hardest situation to reach is a back-pressured output with a second window already captured behind it. In that state the lanes must freeze at the first tap of the new window while the old result stays on the port. The bench gets there by lowering `out_ready` before sending two windows and then offering a third. While the hold lasts it checks at every cycle that the result is stable and that the third is refused. On release it checks that the second window's sum is intact. Every setting of `cfg_taps` from 0 to 15 is also swept with back-to-back windows. The elements past the active taps are filled with nonzero data so that leaks would show.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // Signed width that holds nfm*kmax products of two dw-bit operands
    function automatic int acc_bits(input int dw, input int nfm, input int kmax);
        return 2 * dw + $clog2(nfm) + $clog2(kmax);
    endfunction

endpackage

// File: rtl/conv_wt_bank.sv
module conv_wt_bank #(
    parameter int DW    = 8,
    parameter int NFM   = 2,
    parameter int NLANE = 2,
    parameter int KMAX  = 9,
    parameter int LW    = 1,
    parameter int XW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [LW-1:0]                 lane_i,
    input  logic [XW-1:0]                 tap_i,
    input  logic [NFM*DW-1:0]             data_i,
    output logic [NLANE*KMAX*NFM*DW-1:0]  w_all_o
);
    localparam int BEAT = NFM * DW;

    logic [NLANE*KMAX*BEAT-1:0] w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (we_i && (int'(lane_i) < NLANE) && (int'(tap_i) < KMAX)) begin
            w_d[(int'(lane_i) * KMAX + int'(tap_i)) * BEAT +: BEAT] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign w_all_o = w_q;
endmodule

// File: rtl/conv_lane_sum.sv
module conv_lane_sum #(
    parameter int DW  = 8,
    parameter int NFM = 2,
    parameter int PW  = 17
) (
    input  logic [NFM*DW-1:0]   x_i,
    input  logic [NFM*DW-1:0]   w_i,
    output logic signed [PW-1:0] psum_o
);
    logic signed [2*DW-1:0] prod [NFM];

    always_comb begin
        psum_o = '0;
        for (int f = 0; f < NFM; f++) begin
            prod[f] = $signed(x_i[f*DW +: DW]) * $signed(w_i[f*DW +: DW]);
            psum_o  = psum_o + PW'(prod[f]);
        end
    end
endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
    import conv_mac_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NFM   = 2,
    parameter int NLANE = 2,
    parameter int KMAX  = 9,
    parameter int TW    = $clog2(KMAX + 1),
    parameter int LW    = (NLANE > 1) ? $clog2(NLANE) : 1,
    parameter int XW    = (KMAX > 1) ? $clog2(KMAX) : 1,
    parameter int AW    = acc_bits(DW, NFM, KMAX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TW-1:0]            cfg_taps,
    input  logic                     wt_valid,
    output logic                     wt_ready,
    input  logic [LW-1:0]            wt_lane,
    input  logic [XW-1:0]            wt_tap,
    input  logic [NFM*DW-1:0]        wt_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [KMAX*NFM*DW-1:0]   in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [NLANE*AW-1:0]      out_data
);
    localparam int BEAT = NFM * DW;
    localparam int PW   = 2 * DW + $clog2(NFM);

    typedef struct packed {
        run_e                     run;
        logic [TW-1:0]            tap;
        logic [KMAX*BEAT-1:0]     win;
        logic [NLANE*AW-1:0]      acc;
        logic                     ovld;
        logic [NLANE*AW-1:0]      odata;
    } state_t;

    state_t s_d, s_q;

    logic [TW-1:0]               teff;
    logic                        stall, adv, last;
    logic [BEAT-1:0]             x_tap;
    logic [NLANE*KMAX*BEAT-1:0]  w_all;
    logic signed [PW-1:0]        psum [NLANE];
    logic signed [AW-1:0]        base [NLANE];
    logic signed [AW-1:0]        nacc [NLANE];

    conv_wt_bank #(
        .DW(DW), .NFM(NFM), .NLANE(NLANE), .KMAX(KMAX), .LW(LW), .XW(XW)
    ) u_wbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wt_valid && wt_ready),
        .lane_i  (wt_lane),
        .tap_i   (wt_tap),
        .data_i  (wt_data),
        .w_all_o (w_all)
    );

    assign x_tap = s_q.win[int'(s_q.tap) * BEAT +: BEAT];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        conv_lane_sum #(.DW(DW), .NFM(NFM), .PW(PW)) u_sum (
            .x_i    (x_tap),
            .w_i    (w_all[(l * KMAX + int'(s_q.tap)) * BEAT +: BEAT]),
            .psum_o (psum[l])
        );
    end

    always_comb begin
        teff  = ((cfg_taps == '0) || (cfg_taps > TW'(KMAX))) ? TW'(KMAX) : cfg_taps;
        stall = s_q.ovld && !out_ready;
        adv   = (s_q.run == ST_RUN) && !stall;
        last  = adv && (s_q.tap == teff - TW'(1));

        s_d = s_q;
        if (s_q.ovld && out_ready) s_d.ovld = 1'b0;

        for (int l = 0; l < NLANE; l++) begin
            base[l] = (s_q.tap == '0) ? '0 : $signed(s_q.acc[l*AW +: AW]);
            nacc[l] = base[l] + AW'(psum[l]);
        end

        if (adv) begin
            for (int l = 0; l < NLANE; l++) s_d.acc[l*AW +: AW] = nacc[l];
            s_d.tap = s_q.tap + TW'(1);
            if (last) begin
                for (int l = 0; l < NLANE; l++) s_d.odata[l*AW +: AW] = nacc[l];
                s_d.ovld = 1'b1;
                s_d.tap  = '0;
                s_d.run  = ST_IDLE;
            end
        end

        if (in_valid && in_ready) begin
            s_d.win = in_data;
            s_d.tap = '0;
            s_d.run = ST_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = (s_q.run == ST_IDLE) || last;
    assign wt_ready  = (s_q.run == ST_IDLE);
    assign out_valid = s_q.ovld;
    assign out_data  = s_q.odata;
endmodule

// File: rtl/conv_mac_chk.sv
module conv_mac_chk #(
    parameter int DW    = 8,
    parameter int NFM   = 2,
    parameter int NLANE = 2,
    parameter int KMAX  = 9,
    parameter int TW    = 4,
    parameter int AW    = 21
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [TW-1:0]        cfg_taps,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 wt_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NLANE*AW-1:0]  out_data
);
    localparam longint LIM = longint'(NFM) * longint'(KMAX) * (longint'(1) << (2 * DW - 2));

    logic multi;
    logic in_range;

    always_comb begin
        multi    = (cfg_taps != TW'(1));
        in_range = 1'b1;
        for (int l = 0; l < NLANE; l++) begin
            if ((longint'($signed(out_data[l*AW +: AW])) > LIM) ||
                (longint'($signed(out_data[l*AW +: AW])) < -LIM)) in_range = 1'b0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_WT_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !wt_ready); // R2
    AST_CE_SUBRATE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && multi) |=> !in_ready); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> in_range); // R9
    AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && multi) |=> !out_valid); // R10
endmodule

bind conv_mac_engine conv_mac_chk #(
    .DW(DW), .NFM(NFM), .NLANE(NLANE), .KMAX(KMAX), .TW(TW), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_taps  (cfg_taps),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wt_ready  (wt_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_conv_mac_engine.sv
module sim_conv_mac_engine;
    localparam int DW = 8, NFM = 2, NLANE = 2, KMAX = 9, TW = 4, AW = 21;
    localparam int OW = NLANE * AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] cfg_taps = '0;
    logic wt_valid = 1'b0, wt_ready;
    logic [0:0] wt_lane = '0;
    logic [3:0] wt_tap = '0;
    logic [NFM*DW-1:0] wt_data = '0;
    logic in_valid = 1'b0, in_ready;
    logic [KMAX*NFM*DW-1:0] in_data = '0;
    logic out_valid, out_ready = 1'b1;
    logic [OW-1:0] out_data;

    int checks = 0, failures = 0, cyc = 0;
    bit chk_lat = 1'b1;
    int wt [NLANE][KMAX][NFM];
    int xw [KMAX][NFM];
    logic [OW-1:0] expq [$];
    int tgtq [$];
    bit seen = 1'b0;

    always #10 clk = ~clk;

    conv_mac_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_taps(cfg_taps),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_lane(wt_lane), .wt_tap(wt_tap), .wt_data(wt_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int t);
        return (t == 0 || t > KMAX) ? KMAX : t;
    endfunction

    function automatic logic [OW-1:0] model(input int te);
        logic [OW-1:0] r;
        int s;
        for (int l = 0; l < NLANE; l++) begin
            s = 0;
            for (int t = 0; t < te; t++)
                for (int f = 0; f < NFM; f++) s += xw[t][f] * wt[l][t][f];
            r[l*AW +: AW] = AW'(s);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Output monitor (R4, R5, R6, R7, R8 data hold)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected out_valid", 64'(out_data), 64'(0));
            end else begin
                chk(out_data == expq[0], "R4 lane sums", 64'(out_data), 64'(expq[0]));
                if (!seen && chk_lat)
                    chk(cyc == tgtq[0], "R7 latency", 64'(cyc), 64'(tgtq[0]));
                seen = 1'b1;
                if (out_ready) begin
                    void'(expq.pop_front());
                    void'(tgtq.pop_front());
                    seen = 1'b0;
                end
            end
        end
    end

    task automatic load_wts();
        for (int l = 0; l < NLANE; l++)
            for (int t = 0; t < KMAX; t++) begin
                wt_valid = 1'b1;
                wt_lane  = 1'(l);
                wt_tap   = 4'(t);
                for (int f = 0; f < NFM; f++) wt_data[f*DW +: DW] = DW'(wt[l][t][f]);
                forever begin
                    @(negedge clk);
                    if (wt_ready) break;
                end
                @(posedge clk); #1;
            end
        wt_valid = 1'b0;
    endtask

    task automatic push_win(input int te, output int acc_cyc);
        bit took;
        for (int t = 0; t < KMAX; t++)
            for (int f = 0; f < NFM; f++) in_data[(t*NFM + f)*DW +: DW] = DW'(xw[t][f]);
        in_valid = 1'b1;
        took = 1'b0;
        acc_cyc = 0;
        while (!took) begin
            @(negedge clk);
            took = in_ready;
            acc_cyc = cyc;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        expq.push_back(model(te));
        tgtq.push_back(acc_cyc + 1 + te);
    endtask

    task automatic drain();
        while (expq.size() != 0) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    task automatic fill_rand(input bit zero);
        for (int t = 0; t < KMAX; t++)
            for (int f = 0; f < NFM; f++)
                xw[t][f] = zero ? 0 : int'($urandom_range(255)) - 128;
    endtask

    initial begin
        int a, prev, te;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));
        chk(wt_ready == 1'b1, "R1 wt_ready", 64'(wt_ready), 64'(1));
        @(posedge clk); #1;

        // Sweep of every cfg_taps encoding (R4, R5, R6, R7, R10)
        for (int tc = 0; tc < 16; tc++) begin
            cfg_taps = 4'(tc);
            te = eff(tc);
            for (int l = 0; l < NLANE; l++)
                for (int t = 0; t < KMAX; t++)
                    for (int f = 0; f < NFM; f++) wt[l][t][f] = int'($urandom_range(255)) - 128;
            load_wts();
            prev = 0;
            for (int rep = 0; rep < 4; rep++) begin
                fill_rand(rep == 1);   // rep 1 all-zero window after a random one: R5
                push_win(te, a);
                if (rep > 0) chk(a - prev == te, "R10 accept spacing", 64'(a - prev), 64'(te));
                prev = a;
                if (rep == 0 && te > 1) begin
                    @(negedge clk);
                    chk(wt_ready == 1'b0, "R2 weights locked mid-window", 64'(wt_ready), 64'(0));
                    chk(in_ready == 1'b0, "R3 enable sub-rate", 64'(in_ready), 64'(0));
                    @(posedge clk); #1;
                end
            end
            drain();
        end

        // Extreme operands (R9)
        cfg_taps = 4'd9;
        for (int l = 0; l < NLANE; l++)
            for (int t = 0; t < KMAX; t++)
                for (int f = 0; f < NFM; f++) wt[l][t][f] = (l == 0) ? -128 : 127;
        load_wts();
        for (int t = 0; t < KMAX; t++)
            for (int f = 0; f < NFM; f++) xw[t][f] = -128;
        push_win(9, a);
        drain();
        chk(1'b1, "R9 extreme window issued", 64'(0), 64'(0));

        // Back-pressure with a captured second window (R8)
        cfg_taps = 4'd4;
        chk_lat = 1'b0;
        out_ready = 1'b0;
        fill_rand(1'b0);
        push_win(4, a);
        fill_rand(1'b0);
        push_win(4, a);
        in_valid = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8 valid held", 64'(out_valid), 64'(1));
            chk(in_ready == 1'b0, "R8 third window refused", 64'(in_ready), 64'(0));
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        drain();
        chk(expq.size() == 0, "R8 both results delivered", 64'(expq.size()), 64'(0));
        chk(out_valid == 1'b0, "R7 single-cycle valid", 64'(out_valid), 64'(0));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule